// File: doc/BRIEF.md
# Virtualization-Aware Local Interrupt Selector

This block decides which local interrupt a hart should take next. It receives the raw pending and enable vectors, the delegation mask, the current privilege level, a flag for guest (virtualized) execution, and three global enable bits. One enable bit is for machine level. The other two are for supervisor level: one for the guest view and one for the host view. The block reports whether an interrupt is due, the cause index of the chosen interrupt, and whether the trap must go to the host supervisor rather than to the guest.

During guest execution, ordinary interrupts that the host may take have priority. When any of them is eligible, one of them is chosen and the host-trap flag is raised. Only when none is eligible are the three guest-supervisor pending bits moved down one position onto the supervisor positions. They then pass through the normal delegation filter. Among the candidates, the lowest-numbered bit wins. The result is registered, so it is presented one clock after the inputs.

Top module: `vhirq_select`

## Requirements
- R1: The ordinary set is pending AND enable with bits 2, 6 and 10 (guest-supervisor software, timer, external) forced to zero.
- R2: In guest mode with no host interrupt selected, the candidates come only from bits 2, 6 and 10 of pending AND enable, moved to positions 1, 5 and 9. Outside guest mode those bits are never candidates.
- R3: Privilege is encoded in 2 bits: user = 0, supervisor = 1, machine = 3. Code 2 compares numerically between supervisor and machine.
- R4: Machine-level (non-delegated) candidates are allowed when the privilege is below 3, or is 3 with `m_gie_i` high.
- R5: Delegated candidates are allowed when the privilege is 0, or is 1 with the supervisor enable high. The supervisor enable is `s_gie_guest_i` in guest mode and `s_gie_host_i` otherwise.
- R6: In guest mode, if the ordinary set is non-empty and the host condition holds (privilege 0, or 1 with `s_gie_host_i`), the choice is made from the ordinary set regardless of delegation. In that case `host_trap_o` is 1 and guest bits are ignored.
- R7: A candidate whose delegation bit is 1 is gated only by R5. A candidate whose delegation bit is 0 is gated only by R4.
- R8: The cause is the index of the lowest set candidate bit. With no candidate, `take_o`, `cause_o` and `host_trap_o` are all 0.
- R9: Outputs are registered: they reflect the inputs sampled at the previous rising edge. A synchronous active-high reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | XLEN | Raw interrupt pending bits |
| enab_i | input | XLEN | Per-interrupt enable bits |
| deleg_i | input | XLEN | Delegation mask, 1 sends to supervisor |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Hart is executing a guest |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_guest_i | input | 1 | Supervisor global enable, guest view |
| s_gie_host_i | input | 1 | Supervisor global enable, host view |
| take_o | output | 1 | An interrupt is selected |
| cause_o | output | $clog2(XLEN) | Index of the selected interrupt |
| host_trap_o | output | 1 | Selected interrupt must trap to the host supervisor |

## Verification
Every result (take, cause and host-trap flag) is due exactly one rising edge after the inputs that produce it. The reset clearing is due at the first edge with reset high. The bench changes the inputs on a falling edge and compares the outputs on the following falling edge, so exactly one register stage lies between stimulus and sample. A behavioural model runs alongside and predicts each cycle's outputs. It is checked with directed cases for each gating rule and then with randomized vectors, privileges and mode flags.

// File: rtl/vhirq_pkg.sv
package vhirq_pkg;
  typedef enum logic [1:0] {
    PRV_USER = 2'd0,
    PRV_SUPV = 2'd1,
    PRV_RSVD = 2'd2,
    PRV_MACH = 2'd3
  } priv_e;

  // guest-supervisor bit positions; each lands one position lower
  localparam int GST_SW = 2;
  localparam int GST_TM = 6;
  localparam int GST_EX = 10;
  localparam int MIN_XLEN = GST_EX + 1;
endpackage

// File: rtl/vhirq_enables.sv
module vhirq_enables
  import vhirq_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       m_gie_i,
  input  logic       s_gie_guest_i,
  input  logic       s_gie_host_i,
  output logic       m_ok_o,
  output logic       s_ok_o,
  output logic       h_ok_o
);
  logic below_s, at_s, s_bit;

  always_comb begin
    below_s = (priv_i < PRV_SUPV);
    at_s    = (priv_i == PRV_SUPV);
    s_bit   = virt_i ? s_gie_guest_i : s_gie_host_i;
    m_ok_o  = (priv_i < PRV_MACH) || ((priv_i == PRV_MACH) && m_gie_i);
    s_ok_o  = below_s || (at_s && s_bit);
    h_ok_o  = below_s || (at_s && s_gie_host_i);
  end
endmodule

// File: rtl/vhirq_filter.sv
module vhirq_filter
  import vhirq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] enab_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic            virt_i,
  input  logic            m_ok_i,
  input  logic            s_ok_i,
  input  logic            h_ok_i,
  output logic [XLEN-1:0] cand_o,
  output logic            host_hit_o
);
  localparam logic [XLEN-1:0] ONE     = XLEN'(1);
  localparam logic [XLEN-1:0] GST_MSK = (ONE << GST_SW) | (ONE << GST_TM) | (ONE << GST_EX);

  logic [XLEN-1:0] raw, ord, gst, hostv, base, gated;

  always_comb begin
    raw        = pend_i & enab_i;
    ord        = raw & ~GST_MSK;
    gst        = (raw & GST_MSK) >> 1;
    hostv      = ord & {XLEN{h_ok_i}};
    host_hit_o = virt_i && (|hostv);
    base       = virt_i ? gst : ord;
    gated      = (base & ~deleg_i & {XLEN{m_ok_i}}) |
                 (base &  deleg_i & {XLEN{s_ok_i}});
    cand_o     = host_hit_o ? hostv : gated;
  end
endmodule

// File: rtl/vhirq_lsb.sv
module vhirq_lsb #(
  parameter int XLEN = 64,
  localparam int CW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] vec_i,
  output logic            any_o,
  output logic [CW-1:0]   idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = CW'(i);
    end
  end
endmodule

// File: rtl/vhirq_select.sv
module vhirq_select
  import vhirq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int CW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] enab_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            m_gie_i,
  input  logic            s_gie_guest_i,
  input  logic            s_gie_host_i,
  output logic            take_o,
  output logic [CW-1:0]   cause_o,
  output logic            host_trap_o
);
  localparam logic [XLEN-1:0] ONE   = XLEN'(1);
  localparam logic [XLEN-1:0] S_MSK = (ONE << (GST_SW - 1)) | (ONE << (GST_TM - 1)) |
                                      (ONE << (GST_EX - 1));

  logic            m_ok, s_ok, h_ok, host_hit, sel_any;
  logic [XLEN-1:0] cand;
  logic [CW-1:0]   sel_idx;

  initial begin
    if (XLEN < MIN_XLEN) $error("XLEN too small for guest bit positions");
  end

  vhirq_enables u_en (
    .priv_i(priv_i), .virt_i(virt_i), .m_gie_i(m_gie_i),
    .s_gie_guest_i(s_gie_guest_i), .s_gie_host_i(s_gie_host_i),
    .m_ok_o(m_ok), .s_ok_o(s_ok), .h_ok_o(h_ok)
  );

  vhirq_filter #(.XLEN(XLEN)) u_flt (
    .pend_i(pend_i), .enab_i(enab_i), .deleg_i(deleg_i), .virt_i(virt_i),
    .m_ok_i(m_ok), .s_ok_i(s_ok), .h_ok_i(h_ok),
    .cand_o(cand), .host_hit_o(host_hit)
  );

  vhirq_lsb #(.XLEN(XLEN)) u_lsb (
    .vec_i(cand), .any_o(sel_any), .idx_o(sel_idx)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          take_o      <= 1'b0;
          cause_o     <= '0;
          host_trap_o <= 1'b0;
        end else begin
          take_o      <= sel_any;
          cause_o     <= sel_idx;
          host_trap_o <= host_hit;
        end
      end

      // R6
      host_virt_chk: assert property (@(posedge clk) disable iff (rst)
        host_trap_o |-> $past(virt_i));
      // R9
      rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!take_o && !host_trap_o));
    end else begin : g_comb
      assign take_o      = sel_any;
      assign cause_o     = sel_idx;
      assign host_trap_o = host_hit;
    end
  endgenerate

  // R6
  host_take_chk: assert property (@(posedge clk) disable iff (rst)
    host_trap_o |-> take_o);
  // R8
  idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (cause_o == '0 && !host_trap_o));
  // R8
  pick_member_chk: assert property (@(posedge clk) disable iff (rst)
    sel_any |-> cand[sel_idx]);
  // R2
  guest_land_chk: assert property (@(posedge clk) disable iff (rst)
    (virt_i && !host_hit) |-> ((cand & ~S_MSK) == '0));
endmodule

// File: tb/vhirq_select_test.sv
`timescale 1ns/1ps
module vhirq_select_test;
  localparam int XL = 64;
  localparam int CW = $clog2(XL);

  logic clk = 1'b0, rst = 1'b1;
  logic [XL-1:0] pend = '0, enab = '0, deleg = '0;
  logic [1:0] priv = 2'd0;
  logic virt = 0, mg = 0, sg = 0, sh = 0;
  logic take, ht;
  logic [CW-1:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vhirq_select #(.XLEN(XL)) uut (
    .clk(clk), .rst(rst), .pend_i(pend), .enab_i(enab), .deleg_i(deleg),
    .priv_i(priv), .virt_i(virt), .m_gie_i(mg), .s_gie_guest_i(sg),
    .s_gie_host_i(sh), .take_o(take), .cause_o(cause), .host_trap_o(ht)
  );

  function automatic bit is_gst(int i);
    return (i == 2) || (i == 6) || (i == 10);
  endfunction

  function automatic void model(input logic [XL-1:0] p, e, d, input logic [1:0] pr,
                                input logic v, m, g, h,
                                output logic tk, output int cs, output logic hx);
    logic [XL-1:0] r;
    bit mok, hok, sok, b;
    r = p & e;
    mok = (pr != 2'd3) || m;
    hok = (pr == 2'd0) || (pr == 2'd1 && h);
    sok = (pr == 2'd0) || (pr == 2'd1 && (v ? g : h));
    tk = 0; cs = 0; hx = 0;
    if (v && hok) begin
      for (int i = 0; i < XL; i++) begin
        if (r[i] && !is_gst(i)) begin
          tk = 1; cs = i; hx = 1;
          return;
        end
      end
    end
    for (int i = 0; i < XL; i++) begin
      if (v) b = (i == 1 || i == 5 || i == 9) && r[i+1];
      else   b = r[i] && !is_gst(i);
      if (b && (d[i] ? sok : mok)) begin
        tk = 1; cs = i;
        return;
      end
    end
  endfunction

  task automatic compare(string tag, logic etk, int ecs, logic ehx);
    checks++;
    if (take !== etk || int'(cause) != ecs || ht !== ehx) begin
      fails++;
      $display("FAIL %s: actual take=%0b cause=%0d host=%0b expected take=%0b cause=%0d host=%0b",
               tag, take, cause, ht, etk, ecs, ehx);
    end
  endtask

  // drive after a falling edge, check on the next falling edge (one register)
  task automatic run(string tag, logic [XL-1:0] p, e, d, logic [1:0] pr,
                     logic v, m, g, h);
    logic etk, ehx;
    int ecs;
    pend = p; enab = e; deleg = d; priv = pr; virt = v; mg = m; sg = g; sh = h;
    model(p, e, d, pr, v, m, g, h, etk, ecs, ehx);
    @(negedge clk);
    compare(tag, etk, ecs, ehx);
  endtask

  function automatic logic [XL-1:0] bt(int i);
    return XL'(1) << i;
  endfunction

  initial begin
    logic [XL-1:0] ALL;
    ALL = '1;
    // R9: reset clears outputs even with live inputs
    rst = 1; pend = ALL; enab = ALL; priv = 2'd0;
    @(negedge clk); @(negedge clk);
    compare("R9 reset", 0, 0, 0);
    rst = 0;
    // R1: guest bit alone is not ordinary
    run("R1 guest bit masked", bt(2), ALL, '0, 2'd0, 0, 0, 0, 0);
    run("R1 ordinary bit", bt(2) | bt(3), ALL, '0, 2'd0, 0, 0, 0, 0);
    // R2: guest bit 6 lands on 5
    run("R2 guest shift", bt(6), ALL, bt(5), 2'd0, 1, 0, 0, 0);
    run("R2 guest needs enable", bt(6), ALL & ~bt(6), bt(5), 2'd0, 1, 0, 0, 0);
    // R4: machine gate
    run("R4 machine off", bt(7), ALL, '0, 2'd3, 0, 0, 1, 1);
    run("R4 machine on", bt(7), ALL, '0, 2'd3, 0, 1, 1, 1);
    // R5: guest/host supervisor enable choice
    run("R5 guest gie off", bt(10), ALL, bt(9), 2'd1, 1, 1, 0, 1);
    run("R5 guest gie on", bt(10), ALL, bt(9), 2'd1, 1, 1, 1, 0);
    run("R5 host gie off nonvirt", bt(5), ALL, bt(5), 2'd1, 0, 1, 1, 0);
    // R6: host priority in guest mode
    run("R6 host wins", bt(11) | bt(2), ALL, '0, 2'd0, 1, 0, 0, 0);
    run("R6 host blocked", bt(9) | bt(10), ALL, bt(9), 2'd1, 1, 1, 1, 0);
    // R7: delegation split
    run("R7 delegated blocked", bt(3) | bt(7), ALL, bt(3), 2'd1, 0, 0, 1, 0);
    run("R7 delegated allowed", bt(3) | bt(7), ALL, bt(3), 2'd1, 0, 0, 0, 1);
    // R8: lowest index, top bit, empty
    run("R8 lowest", bt(40) | bt(13) | bt(63), ALL, '0, 2'd0, 0, 0, 0, 0);
    run("R8 top bit", bt(63), ALL, '0, 2'd0, 0, 0, 0, 0);
    run("R8 empty", ALL, '0, '0, 2'd0, 1, 1, 1, 1);
    // R3: code 2 is above supervisor, below machine
    run("R3 code2 deleg", bt(1), ALL, bt(1), 2'd2, 0, 0, 1, 1);
    run("R3 code2 machine", bt(1) | bt(7), ALL, bt(1), 2'd2, 0, 0, 1, 1);
    // R9: reset in mid-run
    rst = 1; @(negedge clk); compare("R9 mid reset", 0, 0, 0); rst = 0;
    // randomized sweep
    for (int n = 0; n < 4000; n++) begin
      logic [XL-1:0] p, e;
      p = {$urandom, $urandom};
      e = {$urandom, $urandom};
      if (n % 3 == 0) p = p & {$urandom, $urandom} & {$urandom, $urandom};
      if (n % 5 == 0) p = p & 64'h0000_0000_0000_0ee6;
      run(n % 2 ? "R6 random" : "R7 random", p, e, {$urandom, $urandom},
          2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule